// File: doc/BRIEF.md
# Register Read-Modify-Write Packet Engine

This block carries out one register update command that arrives as three 32-bit words on a valid/ready stream. The first word is a control word. The second and third words are two operands. The engine reads the addressed destination entry of its local register file and masks it with operand 0. It rotates the masked value left by a programmable amount, then merges operand 1 into it by addition or by bitwise OR, and writes the result back to the same entry. Either operand can be taken literally from the packet, or the packet can name a register-file entry whose current contents are used instead.

The engine sits behind a command parser that has already decoded the packet type; it sees only the packet body. It runs one packet at a time. It drops ready while it reads and writes the file and signals completion with a one-cycle done pulse. A combinational probe read port gives the surrounding logic a view of any entry.

Top module: `regfile_rmw_engine`

## Requirements
- R1: A packet is three words taken in the order control, operand 0, operand 1, each transferred on a clock edge where pkt_valid and pkt_ready are both high. Gaps with pkt_valid low may appear between words.
- R2: Control bits [17:0] address the destination entry. Control bits [23:18] have no effect.
- R3: Control bits [28:24] give a left-rotate amount of 0 to 31, applied circularly over 32 bits to the masked value.
- R4: Control bit 29 = 1 adds operand 1 modulo 2^32 with the carry out discarded; bit 29 = 0 ORs operand 1 in.
- R5: Control bit 31 = 1 makes operand 0 a register address (its bits [17:0]) whose entry contents are used. Control bit 30 = 1 does the same for operand 1. When the bit is clear, the word is used as an immediate.
- R6: The value written back is ((destination AND operand 0) rotated left) merged with operand 1.
- R7: All reads happen before the single write, so an operand that names the destination entry supplies that entry's value from before the update.
- R8: pkt_ready goes low at the edge that accepts the third word and stays low through the done cycle. done is high for exactly one cycle: the cycle after the write-back edge, five cycles after the third word is accepted.
- R9: An address at or above the file depth reads as zero, and a write to such an address leaves every entry unchanged.
- R10: After reset every entry holds zero, pkt_ready is high and done is low.
- R11: probe_data shows the contents of entry probe_addr in the same cycle, with the R9 rule for out-of-range addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Packet word valid |
| pkt_ready | output | 1 | Engine can take a packet word |
| pkt_data | input | 32 | Packet word |
| done | output | 1 | One-cycle pulse after the write-back |
| probe_addr | input | 18 | Probe read address |
| probe_data | output | 32 | Probe read data |

## Verification
The hardest case to reach is a packet whose operands are register references that point back at the destination entry. Only then does it show whether the reads come before the write. Reaching it takes a file preloaded with known non-trivial values. The stimulus builds these values with earlier OR-mode packets that use a zero mask, and it then issues self-referencing packets and packets whose sources lie outside the file. A second hard case is a producer that keeps valid high across the busy window. Back-to-back packets with no gaps, and packets with gaps between their words, check that nothing is taken while ready is low.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  localparam int WORD_W  = 32;
  localparam int ADDR_W  = 18;
  localparam int ROT_W   = $clog2(WORD_W);

  typedef struct packed {
    logic              src0_is_reg;
    logic              src1_is_reg;
    logic              add_mode;
    logic [ROT_W-1:0]  rot;
    logic [ADDR_W-1:0] dst;
  } rmw_ctrl_t;

  typedef enum logic [2:0] {
    ST_CTRL,
    ST_OP0,
    ST_OP1,
    ST_RD_DST,
    ST_RD_S0,
    ST_RD_S1,
    ST_WB,
    ST_DONE
  } rmw_state_e;

  function automatic rmw_ctrl_t decode_ctrl(input logic [WORD_W-1:0] w);
    rmw_ctrl_t c;
    c.src0_is_reg = w[31];
    c.src1_is_reg = w[30];
    c.add_mode    = w[29];
    c.rot         = w[28:24];
    c.dst         = w[ADDR_W-1:0];
    return c;
  endfunction

endpackage

// File: rtl/rmw_regfile.sv
module rmw_regfile
  import rmw_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] pr_addr,
  output logic [WORD_W-1:0] pr_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  ent_we;
  logic              wr_in_range;

  assign wr_in_range = (wr_addr < LIMIT);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ent_we[i] = wr_en && wr_in_range && (wr_addr[IDX_W-1:0] == IDX_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ent_we[i]) mem[i] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr < LIMIT) rd_data = mem[rd_addr[IDX_W-1:0]];
  end

  always_comb begin
    pr_data = '0;
    if (pr_addr < LIMIT) pr_data = mem[pr_addr[IDX_W-1:0]];
  end

  // R9: at most one entry is touched by a write
  always_comb begin
    p_one_entry_written_r9: assert ($onehot0(ent_we));
  end

endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
(
  input  logic [WORD_W-1:0] dst_val,
  input  logic [WORD_W-1:0] src0,
  input  logic [WORD_W-1:0] src1,
  input  logic [ROT_W-1:0]  rot,
  input  logic              add_mode,
  output logic [WORD_W-1:0] result
);

  logic [WORD_W-1:0] masked;
  logic [WORD_W-1:0] rotated;
  logic [ROT_W:0]    back_sh;

  assign masked  = dst_val & src0;
  assign back_sh = (ROT_W+1)'(WORD_W) - {1'b0, rot};
  assign rotated = (masked << rot) | (masked >> back_sh);

  always_comb begin
    if (add_mode) result = rotated + src1;
    else          result = rotated | src1;
  end

  always_comb begin
    p_rotate_keeps_ones_r3: assert ($countones(rotated) == $countones(masked));
    if (!add_mode) begin
      p_or_keeps_src1_r4: assert ((result & src1) == src1);
    end
  end

endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  output logic              pkt_ready,
  input  logic [WORD_W-1:0] pkt_data,
  output logic              done,
  output logic [ADDR_W-1:0] rf_rd_addr,
  input  logic [WORD_W-1:0] rf_rd_data,
  output logic              rf_wr_en,
  output logic [ADDR_W-1:0] rf_wr_addr,
  output logic [WORD_W-1:0] rf_wr_data,
  output logic [WORD_W-1:0] alu_dst,
  output logic [WORD_W-1:0] alu_src0,
  output logic [WORD_W-1:0] alu_src1,
  output logic [ROT_W-1:0]  alu_rot,
  output logic              alu_add,
  input  logic [WORD_W-1:0] alu_result
);

  rmw_state_e        state_q, state_d;
  rmw_ctrl_t         ctrl_q;
  logic [WORD_W-1:0] op0_q, op1_q, dst_q;
  logic [WORD_W-1:0] op0_d, op1_d, dst_d;
  logic              ctrl_en, op0_en, op1_en, dst_en;
  logic              accept;

  assign pkt_ready = (state_q == ST_CTRL) || (state_q == ST_OP0) || (state_q == ST_OP1);
  assign accept    = pkt_valid && pkt_ready;

  // next-state and operand capture selection
  always_comb begin
    state_d = state_q;
    ctrl_en = 1'b0;
    op0_en  = 1'b0;
    op1_en  = 1'b0;
    dst_en  = 1'b0;
    op0_d   = pkt_data;
    op1_d   = pkt_data;
    dst_d   = rf_rd_data;
    rf_rd_addr = ctrl_q.dst;
    unique case (state_q)
      ST_CTRL: if (accept) begin
        ctrl_en = 1'b1;
        state_d = ST_OP0;
      end
      ST_OP0: if (accept) begin
        op0_en  = 1'b1;
        state_d = ST_OP1;
      end
      ST_OP1: if (accept) begin
        op1_en  = 1'b1;
        state_d = ST_RD_DST;
      end
      ST_RD_DST: begin
        rf_rd_addr = ctrl_q.dst;
        dst_en     = 1'b1;
        state_d    = ST_RD_S0;
      end
      ST_RD_S0: begin
        rf_rd_addr = op0_q[ADDR_W-1:0];
        op0_d      = rf_rd_data;
        op0_en     = ctrl_q.src0_is_reg;
        state_d    = ST_RD_S1;
      end
      ST_RD_S1: begin
        rf_rd_addr = op1_q[ADDR_W-1:0];
        op1_d      = rf_rd_data;
        op1_en     = ctrl_q.src1_is_reg;
        state_d    = ST_WB;
      end
      ST_WB:   state_d = ST_DONE;
      ST_DONE: state_d = ST_CTRL;
      default: state_d = ST_CTRL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_CTRL;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= decode_ctrl(pkt_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      op0_q <= '0;
    else if (op0_en) op0_q <= op0_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      op1_q <= '0;
    else if (op1_en) op1_q <= op1_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dst_q <= '0;
    else if (dst_en) dst_q <= dst_d;
  end

  assign alu_dst    = dst_q;
  assign alu_src0   = op0_q;
  assign alu_src1   = op1_q;
  assign alu_rot    = ctrl_q.rot;
  assign alu_add    = ctrl_q.add_mode;

  assign rf_wr_en   = (state_q == ST_WB);
  assign rf_wr_addr = ctrl_q.dst;
  assign rf_wr_data = alu_result;
  assign done       = (state_q == ST_DONE);

  p_busy_after_last_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OP1 && pkt_valid && pkt_ready) |=> !pkt_ready);

  p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |=> (done && !pkt_ready));

  p_done_single_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_write_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |=> !rf_wr_en);

endmodule

// File: rtl/regfile_rmw_engine.sv
module regfile_rmw_engine
  import rmw_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pkt_valid,
  output logic        pkt_ready,
  input  logic [31:0] pkt_data,
  output logic        done,
  input  logic [17:0] probe_addr,
  output logic [31:0] probe_data
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;

  logic [ADDR_W-1:0] rf_rd_addr, rf_wr_addr;
  logic [WORD_W-1:0] rf_rd_data, rf_wr_data;
  logic              rf_wr_en;
  logic [WORD_W-1:0] alu_dst, alu_src0, alu_src1, alu_result;
  logic [ROT_W-1:0]  alu_rot;
  logic              alu_add;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  rmw_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .pkt_valid  (pkt_valid),
    .pkt_ready  (pkt_ready),
    .pkt_data   (pkt_data),
    .done       (done),
    .rf_rd_addr (rf_rd_addr),
    .rf_rd_data (rf_rd_data),
    .rf_wr_en   (rf_wr_en),
    .rf_wr_addr (rf_wr_addr),
    .rf_wr_data (rf_wr_data),
    .alu_dst    (alu_dst),
    .alu_src0   (alu_src0),
    .alu_src1   (alu_src1),
    .alu_rot    (alu_rot),
    .alu_add    (alu_add),
    .alu_result (alu_result)
  );

  rmw_alu u_alu (
    .dst_val  (alu_dst),
    .src0     (alu_src0),
    .src1     (alu_src1),
    .rot      (alu_rot),
    .add_mode (alu_add),
    .result   (alu_result)
  );

  rmw_regfile #(.DEPTH(DEPTH)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .rd_addr (rf_rd_addr),
    .rd_data (rf_rd_data),
    .pr_addr (probe_addr),
    .pr_data (probe_data),
    .wr_en   (rf_wr_en),
    .wr_addr (rf_wr_addr),
    .wr_data (rf_wr_data)
  );

endmodule

// File: tb/test_regfile_rmw_engine.sv
module test_regfile_rmw_engine;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pkt_valid;
  logic        pkt_ready;
  logic [31:0] pkt_data;
  logic        done;
  logic [17:0] probe_addr;
  logic [31:0] probe_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit cmp_en   = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regfile_rmw_engine #(.DEPTH(DEPTH)) i_regfile_rmw_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkt_valid  (pkt_valid),
    .pkt_ready  (pkt_ready),
    .pkt_data   (pkt_data),
    .done       (done),
    .probe_addr (probe_addr),
    .probe_data (probe_data)
  );

  // behavioural reference model
  logic [31:0] m_mem [DEPTH];
  logic [31:0] m_words [$];
  int          m_cnt;
  logic [17:0] m_waddr;
  logic [31:0] m_wdata;

  function automatic logic [31:0] m_read(input logic [17:0] a);
    if (a < DEPTH) return m_mem[a];
    return 32'h0;
  endfunction

  function automatic logic [31:0] m_rotl(input logic [31:0] v, input int r);
    logic [31:0] t = v;
    for (int k = 0; k < r; k++) t = {t[30:0], t[31]};
    return t;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = 32'h0;
      m_words.delete();
      m_cnt = 0;
    end else if (m_cnt > 0) begin
      if (m_cnt == 2 && m_waddr < DEPTH) m_mem[m_waddr] = m_wdata;
      m_cnt = m_cnt - 1;
    end else if (pkt_valid) begin
      m_words.push_back(pkt_data);
      if (m_words.size() == 3) begin
        logic [31:0] c, d, s0, s1, rr;
        c  = m_words[0];
        d  = m_read(c[17:0]);
        s0 = c[31] ? m_read(m_words[1][17:0]) : m_words[1];
        s1 = c[30] ? m_read(m_words[2][17:0]) : m_words[2];
        rr = m_rotl(d & s0, int'(c[28:24]));
        m_wdata = c[29] ? (rr + s1) : (rr | s1);
        m_waddr = c[17:0];
        m_words.delete();
        m_cnt = 5;
      end
    end
  end

  // per-cycle comparison, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (cmp_en && !finished) begin
      n_checks++;
      if (pkt_ready !== (m_cnt == 0)) begin
        n_fail++;
        $display("FAIL R8 pkt_ready actual=%0b expected=%0b", pkt_ready, (m_cnt == 0));
      end
      n_checks++;
      if (done !== (m_cnt == 1)) begin
        n_fail++;
        $display("FAIL R8 done actual=%0b expected=%0b", done, (m_cnt == 1));
      end
      n_checks++;
      if (probe_data !== m_read(probe_addr)) begin
        n_fail++;
        $display("FAIL R11 probe[%0h] actual=%h expected=%h", probe_addr, probe_data,
                 m_read(probe_addr));
      end
    end
  end

  task automatic chk(input string tag, input logic [17:0] a, input logic [31:0] exp);
    @(negedge clk);
    probe_addr = a;
    #1;
    n_checks++;
    if (probe_data !== exp) begin
      n_fail++;
      $display("FAIL %s entry %0h actual=%h expected=%h", tag, a, probe_data, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the handshake edge
  task automatic put_word(input logic [31:0] w);
    bit seen;
    pkt_valid = 1'b1;
    pkt_data  = w;
    do begin
      seen = pkt_ready;
      @(negedge clk);
    end while (!seen);
    pkt_valid = 1'b0;
    pkt_data  = 32'hx;
  endtask

  task automatic send_pkt(input logic [31:0] c, input logic [31:0] a, input logic [31:0] b,
                          input int gap, input bit wait_idle);
    put_word(c);
    repeat (gap) @(negedge clk);
    put_word(a);
    repeat (gap) @(negedge clk);
    put_word(b);
    if (wait_idle) begin
      while (!pkt_ready) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n      = 1'b0;
    pkt_valid  = 1'b0;
    pkt_data   = 32'h0;
    probe_addr = 18'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;

    // R10: reset state
    chk_bit("R10 pkt_ready after reset", pkt_ready, 1'b1);
    chk_bit("R10 done after reset", done, 1'b0);
    for (int i = 0; i < DEPTH; i++) chk("R10", 18'(i), 32'h0);

    // R1: preload through OR packets with a zero mask, with gaps between words
    send_pkt(32'h0000_0001, 32'h0, 32'hF0F0_1234, 2, 1'b1);
    chk("R1", 18'd1, 32'hF0F0_1234);
    send_pkt(32'h0000_0002, 32'h0, 32'h0000_00FF, 0, 1'b1);
    chk("R1", 18'd2, 32'h0000_00FF);
    send_pkt(32'h0000_0003, 32'h0, 32'h8000_0001, 1, 1'b1);
    chk("R1", 18'd3, 32'h8000_0001);

    // R3 R6: mask, rotate by 8, OR immediate
    send_pkt(32'h0800_0001, 32'hFFFF_0000, 32'h0000_0005, 0, 1'b1);
    chk("R3 R6", 18'd1, 32'hF000_00F5);

    // R4: add wraps modulo 2^32
    send_pkt(32'h2100_0003, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 0, 1'b1);
    chk("R4", 18'd3, 32'h0000_0001);

    // R5: both operands from registers, rotate 31, add
    send_pkt(32'hFF00_0002, 32'h0000_0001, 32'h0000_0003, 0, 1'b1);
    chk("R5", 18'd2, 32'h8000_007B);

    // R7: both operands name the destination itself
    send_pkt(32'hC400_0001, 32'h0000_0001, 32'h0000_0001, 0, 1'b1);
    chk("R7", 18'd1, 32'hF000_0FFF);

    // R9: out-of-range source reads zero
    send_pkt(32'h8000_0002, 32'h0000_0100, 32'h0000_0077, 0, 1'b1);
    chk("R9", 18'd2, 32'h0000_0077);
    // R9: out-of-range destination write is dropped
    send_pkt(32'h0000_0020, 32'hFFFF_FFFF, 32'h0000_DEAD, 0, 1'b1);
    chk("R9", 18'h20, 32'h0);
    chk("R9", 18'd0, 32'h0);
    chk("R9", 18'd2, 32'h0000_0077);

    // R2: top entry, with control bits 23:18 set
    send_pkt(32'h00FC_000F, 32'h0, 32'h1234_5678, 0, 1'b1);
    chk("R2", 18'd15, 32'h1234_5678);
    chk("R2", 18'd3, 32'h0000_0001);

    // R8 R1: back-to-back packets with valid held into the busy window
    send_pkt(32'h0000_0004, 32'h0, 32'h0000_00A0, 0, 1'b0);
    send_pkt(32'h2000_0004, 32'hFFFF_FFFF, 32'h0000_0001, 0, 1'b1);
    chk("R8", 18'd4, 32'h0000_00A1);

    // R3: rotate by zero keeps position
    send_pkt(32'h0000_0005, 32'h0, 32'h8000_0000, 0, 1'b1);
    send_pkt(32'h0000_0005, 32'hFFFF_FFFF, 32'h0, 0, 1'b1);
    chk("R3", 18'd5, 32'h8000_0000);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule